// File: doc/BRIEF.md
# Half-Duplex Line Bridge

This block joins two open-drain style signal lines, one facing a card and one facing a host controller, so that either end can pull its line low and have that low level repeated on the far line. In logic terms each line is seen as a sampled input level, and the bridge answers on each side with a drive-low enable and an active pull-up enable. The electrical side (resistors, level shifting, output stages) lives outside and is not modelled here.

Whichever line is first seen to fall is taken as the master for that transfer. Falling edges on the other line are then ignored until the transfer is over. After a fixed number of system clock cycles the bridge pulls the other line, the slave, low. When the master lets go, the bridge stops pulling the slave low and drives it high for the same number of cycles to speed up the rising edge. It then returns to idle. A master pulse that ends before the delay has run out is dropped and nothing is repeated. A global enable holds every lane idle outside an active session. The block holds a parameterised number of identical lanes: three by default, one for data and two auxiliary.

Top module: `hdx_line_bridge`

## Requirements
- R1: After reset, and in idle, all four outputs of every lane are 0 (neither side driven low, no pull-up).
- R2: When the card line falls first, host_drive_low rises exactly DELAY_CYC+2 clock edges after the first edge that samples the low card level. The card-side outputs stay 0 throughout the transfer.
- R3: When the host line falls first, card_drive_low rises exactly DELAY_CYC+2 edges after the first edge that samples the low host level. The host-side outputs stay 0.
- R4: When both lines are first sampled low at the same edge, the card side becomes master.
- R5: Once a master is chosen, a falling edge on the slave line does not change the master and never drives the master's side.
- R6: For a master low pulse of L cycles with L > DELAY_CYC, the slave is driven low for exactly L-DELAY_CYC cycles. The slave's pull-up is then asserted for exactly DELAY_CYC cycles, starting the cycle the low drive drops, after which the lane is idle. A side never has drive-low and pull-up asserted together.
- R7: A master low pulse of L <= DELAY_CYC cycles produces no drive-low and no pull-up on either side.
- R8: While enable is 0, all outputs of every lane are 0 one edge later and no transfer starts. A line that is already low when enable returns to 1 does not start a transfer.
- R9: Lanes are independent: activity on one lane leaves the outputs of every other lane at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Session enable; 0 forces all lanes idle |
| card_in | input | NUM_LANES | Sampled level of each card-side line (1 = high) |
| host_in | input | NUM_LANES | Sampled level of each host-side line (1 = high) |
| card_drive_low | output | NUM_LANES | Pull the card-side line low |
| card_pullup | output | NUM_LANES | Active pull-up pulse on the card-side line |
| host_drive_low | output | NUM_LANES | Pull the host-side line low |
| host_pullup | output | NUM_LANES | Active pull-up pulse on the host-side line |

## Verification
The bench sweeps the master pulse length from one cycle up to past the delay, on every lane and from both sides. It counts drive-low and pull-up cycles against L-DELAY_CYC and DELAY_CYC. An off-by-one in the delay counter or the abort test shows up as a one-cycle error at the L = DELAY_CYC and L = DELAY_CYC+1 boundary. It also drops the slave line during the delay window: a bridge without the edge lockout would swap master and drive the card side. The same-edge tie, where a wrong priority drives the card instead of the host, is tested too. Enable is dropped in mid-transfer and raised again with a line still low. A design that kept its state, or saw a stale level as a new falling edge, would drive a line with no real edge behind it.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_WAIT = 2'd1,
    LN_COPY = 2'd2,
    LN_PULL = 2'd3
  } lane_state_e;

  // Bits needed to count 0 .. delay-1.
  function automatic int unsigned cnt_width(input int unsigned delay);
    return (delay < 2) ? 1 : $clog2(delay);
  endfunction

  // Edges from the first sampling edge of a master fall to the slave low drive:
  // two synchronizer stages, then delay cycles in the wait phase.
  function automatic int unsigned xfer_latency(input int unsigned delay);
    return delay + 2;
  endfunction

endpackage

// File: rtl/hdx_sync2.sv
module hdx_sync2 #(
  parameter int unsigned WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {WIDTH{RST_VAL}};
      q      <= {WIDTH{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hdx_lane.sv
module hdx_lane
  import hdx_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic card_raw,
  input  logic host_raw,
  output logic card_drive_low,
  output logic card_pullup,
  output logic host_drive_low,
  output logic host_pullup
);
  localparam int unsigned CW = cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(DELAY_CYC - 1);

  logic card_s, host_s;
  logic card_prev, host_prev;

  hdx_sync2 #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({card_raw, host_raw}),
    .q     ({card_s, host_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_prev <= 1'b1;
      host_prev <= 1'b1;
    end else begin
      card_prev <= card_s;
      host_prev <= host_s;
    end
  end

  // Named internal events
  logic card_fall, host_fall;
  logic master_card, master_card_nx;
  logic master_high;
  logic timer_done;
  logic slave_low, slave_pu;
  lane_state_e state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;

  assign card_fall   = card_prev & ~card_s;
  assign host_fall   = host_prev & ~host_s;
  assign master_high = master_card ? card_s : host_s;
  assign timer_done  = (cnt == CNT_LAST);

  always_comb begin
    state_nx       = state;
    cnt_nx         = cnt;
    master_card_nx = master_card;
    if (!enable) begin
      state_nx       = LN_IDLE;
      cnt_nx         = '0;
      master_card_nx = 1'b0;
    end else begin
      unique case (state)
        LN_IDLE: begin
          cnt_nx = '0;
          if (card_fall) begin
            state_nx       = LN_WAIT;
            master_card_nx = 1'b1;
          end else if (host_fall) begin
            state_nx       = LN_WAIT;
            master_card_nx = 1'b0;
          end
        end
        LN_WAIT: begin
          if (master_high) begin
            state_nx = LN_IDLE;
            cnt_nx   = '0;
          end else if (timer_done) begin
            state_nx = LN_COPY;
            cnt_nx   = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        LN_COPY: begin
          if (master_high) begin
            state_nx = LN_PULL;
            cnt_nx   = '0;
          end
        end
        LN_PULL: begin
          if (timer_done) begin
            state_nx = LN_IDLE;
            cnt_nx   = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        default: begin
          state_nx = LN_IDLE;
          cnt_nx   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= LN_IDLE;
      cnt         <= '0;
      master_card <= 1'b0;
    end else begin
      state       <= state_nx;
      cnt         <= cnt_nx;
      master_card <= master_card_nx;
    end
  end

  assign slave_low = (state == LN_COPY);
  assign slave_pu  = (state == LN_PULL);

  assign host_drive_low = slave_low &  master_card;
  assign host_pullup    = slave_pu  &  master_card;
  assign card_drive_low = slave_low & ~master_card;
  assign card_pullup    = slave_pu  & ~master_card;

  // R6: at most one drive output active on the lane
  p_single_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_drive_low, card_pullup, host_drive_low, host_pullup}));

  // R8: enable low clears every output by the next edge
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(card_drive_low | card_pullup | host_drive_low | host_pullup));

  // R2: the slave is only pulled low while the master was still seen low
  p_low_needs_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_low) |-> $past(!master_high));

  // R6: a pull-up pulse only follows a low drive
  p_pullup_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_pu) |-> $past(slave_low));

  // R5: master choice is locked for the whole transfer
  p_master_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != LN_IDLE) && $past(state != LN_IDLE)) |-> $stable(master_card));

endmodule

// File: rtl/hdx_line_bridge.sv
module hdx_line_bridge #(
  parameter int unsigned NUM_LANES = 3,
  parameter int unsigned DELAY_CYC = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_LANES-1:0] card_in,
  input  logic [NUM_LANES-1:0] host_in,
  output logic [NUM_LANES-1:0] card_drive_low,
  output logic [NUM_LANES-1:0] card_pullup,
  output logic [NUM_LANES-1:0] host_drive_low,
  output logic [NUM_LANES-1:0] host_pullup
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    hdx_lane #(.DELAY_CYC(DELAY_CYC)) u_lane (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (enable),
      .card_raw       (card_in[g]),
      .host_raw       (host_in[g]),
      .card_drive_low (card_drive_low[g]),
      .card_pullup    (card_pullup[g]),
      .host_drive_low (host_drive_low[g]),
      .host_pullup    (host_pullup[g])
    );
  end
endmodule

// File: tb/hdx_line_bridge_tb_top.sv
`timescale 1ns/1ps
module hdx_line_bridge_tb_top;
  localparam int NL = 3;
  localparam int D  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [NL-1:0] ext_card_low = '0;
  logic [NL-1:0] ext_host_low = '0;
  logic [NL-1:0] card_in, host_in;
  logic [NL-1:0] card_dl, card_pu, host_dl, host_pu;

  always #2 clk = ~clk;  // 250 MHz

  // Wired-AND line model: low when either the external party or the bridge pulls it
  assign card_in = ~(ext_card_low | card_dl);
  assign host_in = ~(ext_host_low | host_dl);

  hdx_line_bridge #(.NUM_LANES(NL), .DELAY_CYC(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .card_in(card_in), .host_in(host_in),
    .card_drive_low(card_dl), .card_pullup(card_pu),
    .host_drive_low(host_dl), .host_pullup(host_pu)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input int len);
    return (len > D) ? len - D : 0;
  endfunction

  function automatic int exp_pu(input int len);
    return (len > D) ? D : 0;
  endfunction

  // Master pulse of len cycles on one lane; count slave, master and other-lane activity
  task automatic run_pulse(input int lane, input bit from_card, input int len);
    int low_n = 0, pu_n = 0, mst_n = 0, oth_n = 0, first = -1;
    int win = len + D + 8;
    if (from_card) ext_card_low[lane] = 1'b1; else ext_host_low[lane] = 1'b1;
    for (int t = 0; t < win; t++) begin
      tick();
      if (from_card) begin
        if (host_dl[lane]) begin low_n++; if (first < 0) first = t; end
        if (host_pu[lane]) pu_n++;
        if (card_dl[lane] | card_pu[lane]) mst_n++;
      end else begin
        if (card_dl[lane]) begin low_n++; if (first < 0) first = t; end
        if (card_pu[lane]) pu_n++;
        if (host_dl[lane] | host_pu[lane]) mst_n++;
      end
      for (int o = 0; o < NL; o++)
        if (o != lane && (card_dl[o] | card_pu[o] | host_dl[o] | host_pu[o])) oth_n++;
      if (t == len - 1) begin
        if (from_card) ext_card_low[lane] = 1'b0; else ext_host_low[lane] = 1'b0;
      end
    end
    if (len > D) begin
      chk(from_card ? "R2 latency" : "R3 latency", first, D + 2);
      chk("R6 low cycles", low_n, exp_low(len));
      chk("R6 pullup cycles", pu_n, exp_pu(len));
    end else begin
      chk("R7 short pulse low", low_n, 0);
      chk("R7 short pulse pullup", pu_n, 0);
    end
    chk(from_card ? "R2 master side quiet" : "R3 master side quiet", mst_n, 0);
    chk("R9 other lanes quiet", oth_n, 0);
    chk("R1 idle after", int'(|{card_dl, card_pu, host_dl, host_pu}), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) tick();
    chk("R1 reset outputs", int'({card_dl, card_pu, host_dl, host_pu}), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (4) tick();
    chk("R1 idle outputs", int'({card_dl, card_pu, host_dl, host_pu}), 0);

    // Sweep pulse length across the delay boundary, every lane, both sides
    for (int lane = 0; lane < NL; lane++)
      for (int side = 0; side < 2; side++)
        for (int len = 1; len <= D + 3; len++) begin
          run_pulse(lane, side == 0, len);
          repeat (3) tick();
        end

    // R4: simultaneous fall, card wins
    ext_card_low[1] = 1'b1;
    ext_host_low[1] = 1'b1;
    repeat (D + 3) tick();
    chk("R4 tie host driven", int'(host_dl[1]), 1);
    chk("R4 tie card not driven", int'(card_dl[1]), 0);
    ext_host_low[1] = 1'b0;
    ext_card_low[1] = 1'b0;
    repeat (3) tick();
    chk("R4 tie pullup on host", int'(host_pu[1]), 1);
    repeat (D + 2) tick();

    // R5: slave line falls during the wait window; master must not change
    ext_card_low[2] = 1'b1;
    repeat (2) tick();
    ext_host_low[2] = 1'b1;
    repeat (2) tick();
    ext_host_low[2] = 1'b0;
    begin
      int card_side = 0;
      for (int t = 0; t < D + 4; t++) begin
        tick();
        card_side += int'(card_dl[2] | card_pu[2]);
      end
      chk("R5 slave edge ignored, card side idle", card_side, 0);
      chk("R5 host still driven", int'(host_dl[2]), 1);
    end
    ext_card_low[2] = 1'b0;
    repeat (D + 6) tick();
    chk("R5 back to idle", int'(|{card_dl, card_pu, host_dl, host_pu}), 0);

    // R8: drop enable mid-transfer
    ext_host_low[0] = 1'b1;
    repeat (D + 3) tick();
    chk("R8 copy active before disable", int'(card_dl[0]), 1);
    enable = 1'b0;
    tick();
    chk("R8 outputs cleared", int'({card_dl, card_pu, host_dl, host_pu}), 0);
    ext_host_low[0] = 1'b0;
    repeat (3) tick();
    ext_card_low[0] = 1'b1;
    begin
      int act_n = 0;
      for (int t = 0; t < D + 6; t++) begin
        tick();
        act_n += int'(|{card_dl, card_pu, host_dl, host_pu});
      end
      chk("R8 no transfer while disabled", act_n, 0);
      enable = 1'b1;
      act_n = 0;
      for (int t = 0; t < D + 6; t++) begin
        tick();
        act_n += int'(|{card_dl, card_pu, host_dl, host_pu});
      end
      chk("R8 stale low ignored on re-enable", act_n, 0);
    end
    ext_card_low[0] = 1'b0;
    repeat (4) tick();
    run_pulse(0, 1'b1, D + 4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule